// File: doc/BRIEF.md
# Processor Idle-State Controller

This block tracks the power state of one processor core and drives its clock enable and its cache-snoop enable. Code 0 is the active state, where the core runs instructions. Every other code is an idle state, where the clock is gated off. The core's clock can also be throttled in the active state: a duty-cycle gate opens the clock for a programmable share of each throttle period.

The core enters three kinds of idle state, each through its own request:
- A halt request enters the light state (code 1) in one edge.
- Holding the stop-clock input enters the medium state (code 2).
- A software request with a target code enters the deep state (code 3) or one of the extended states (codes 4 to 7).

Each extended state borrows the wake rules of base state 1, 2 or 3, chosen by a per-state field. Each state from code 2 upward has its own programmed exit latency. During that latency the clock stays off. A one-cycle wake pulse then marks the return to the active state.

Top module: `cstate_ctrl`

## Requirements
- R1: After asynchronous reset, the controller reports code 0 with `clk_en_o`=1, `snoop_en_o`=1 and `wake_o`=0.
- R2: In the active state, `halt_i` moves the controller to code 1 at the next edge with no entry cycle. An interrupt in code 1 returns it to code 0 at the next edge, with zero exit latency.
- R3: In the active state, `stop_clk_i` starts a one-cycle entry phase that reports code 2, followed by the idle phase in code 2. Code 2 wakes on an interrupt or on `stop_clk_i` falling to 0, and keeps snooping.
- R4: A software request `deep_req_i` enters the state named by `deep_tgt_i` through a one-cycle entry phase. A target below 3 is taken as 3.
- R5: When several requests arrive in the active state, the software request wins over stop-clock, and stop-clock wins over halt. An interrupt in the same cycle suppresses every entry.
- R6: An interrupt wakes every idle state.
- R7: In the idle phase of any state whose base is 3, `snoop_en_o` is 0. In such a state a bus-master write wakes the core only when `bm_wake_en_i`=1. A bus-master write has no effect in states whose base is 1 or 2.
- R8: The base of extended state k (4..7) is the field `ext_base_i[2*(k-4)+1 : 2*(k-4)]`. Values 1, 2 and 3 select that base, and 0 selects 3.
- R9: The exit latency of state k (2..7) is `lat_cfg_i[(k-2)*LAT_W +: LAT_W]`. After the edge that takes the wake event, the clock stays off for that many cycles. The controller then reports code 0 with `wake_o` high for exactly one cycle.
- R10: A wake event during the entry phase aborts entry. The controller returns to code 0 at the next edge, with a wake pulse.
- R11: In code 0 with `thr_en_i`=1, `clk_en_o` is high for `thr_duty_i`+1 cycles of every 2^THR_W cycles. With `thr_en_i`=0 it stays high.
- R12: `clk_en_o` is 0 whenever the reported code is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Halt request (light idle) |
| stop_clk_i | input | 1 | Stop-clock level (medium idle) |
| deep_req_i | input | 1 | Software request for a deep or extended state |
| deep_tgt_i | input | 3 | Target code of the software request |
| irq_i | input | 1 | Interrupt pending |
| bm_write_i | input | 1 | Bus-master memory write attempt |
| bm_wake_en_i | input | 1 | Allows bus-master writes to wake base-3 states |
| ext_base_i | input | 8 | Base semantics of extended states 4..7, 2 bits each |
| lat_cfg_i | input | 6*LAT_W | Exit latencies of states 2..7 |
| thr_en_i | input | 1 | Throttle enable |
| thr_duty_i | input | THR_W | Throttle duty (on cycles minus one) |
| clk_en_o | output | 1 | Core clock enable |
| snoop_en_o | output | 1 | Cache snoop enable |
| cstate_o | output | 3 | Current state code |
| wake_o | output | 1 | One-cycle pulse on return to code 0 |

## Verification
The bench uses the default LAT_W=8 and THR_W=4. The 16-cycle throttle period therefore lets a whole window be counted, for both a partial and a full duty.

The bench programs these exit latencies: 0 for code 5, 1 for code 4, 2 for codes 2 and 6, 3 for code 3, and 4 for code 7. This reaches the direct return, the single-cycle countdown and longer countdowns.

The bench sets the bases of extended states 4..7 to 1, 2, 3 and 3. This exercises each base's wake rules through an extended state and tests the bus-master wake on both the deep state and an extended one.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
  localparam int CODE_W   = 3;
  localparam int NUM_CS   = 1 << CODE_W;
  localparam int DEEP_MIN = 3;
  localparam int NUM_EXT  = NUM_CS - 4;
  localparam int NUM_LAT  = NUM_CS - 2;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_ENTER  = 2'd1,
    PH_IDLE   = 2'd2,
    PH_EXIT   = 2'd3
  } phase_e;

  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/cstate_throttle.sv
module cstate_throttle #(
  parameter int THR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [THR_W-1:0] duty_i,
  output logic             gate_o
);
  logic [THR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign gate_o = !en_i || (cnt_q <= duty_i);
endmodule

// File: rtl/cstate_exit_timer.sv
module cstate_exit_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] val_i,
  output logic             last_o
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == LAT_W'(1));
endmodule

// File: rtl/cstate_wake_eval.sv
module cstate_wake_eval
  import cstate_pkg::*;
(
  input  code_t                code_i,
  input  logic [2*NUM_EXT-1:0] ext_base_i,
  input  logic                 irq_i,
  input  logic                 bm_write_i,
  input  logic                 bm_wake_en_i,
  input  logic                 stop_clk_i,
  output logic [1:0]           sem_o,
  output logic                 wake_o
);
  logic [NUM_CS-1:0][1:0] sem_tab;

  generate
    for (genvar k = 0; k < NUM_CS; k++) begin : g_sem
      if (k < 4) begin : g_base
        assign sem_tab[k] = 2'(k);
      end else begin : g_ext
        logic [1:0] fld;
        assign fld        = ext_base_i[2*(k-4) +: 2];
        assign sem_tab[k] = (fld == 2'd0) ? 2'd3 : fld;
      end
    end
  endgenerate

  assign sem_o = sem_tab[code_i];

  always_comb begin
    wake_o = irq_i;
    if (sem_o == 2'd3 && bm_write_i && bm_wake_en_i) wake_o = 1'b1;
    // stop-clock release only wakes the state it entered
    if (code_i == CODE_W'(2) && !stop_clk_i)         wake_o = 1'b1;
  end
endmodule

// File: rtl/cstate_fsm.sv
module cstate_fsm
  import cstate_pkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             stop_clk_i,
  input  logic             deep_req_i,
  input  code_t            deep_tgt_i,
  input  logic             irq_i,
  input  logic             wake_ev_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             timer_last_i,
  output phase_e           phase_o,
  output code_t            code_o,
  output logic             wake_o,
  output logic             load_o
);
  phase_e phase_q, phase_d;
  code_t  code_q, code_d;
  logic   wake_q, wake_d;
  code_t  tgt_clamped;

  assign tgt_clamped = (deep_tgt_i < CODE_W'(DEEP_MIN)) ? CODE_W'(DEEP_MIN) : deep_tgt_i;
  assign load_o      = (phase_q == PH_IDLE) && wake_ev_i && (lat_i != '0);

  always_comb begin
    phase_d = phase_q;
    code_d  = code_q;
    wake_d  = 1'b0;
    unique case (phase_q)
      PH_ACTIVE: begin
        if (!irq_i) begin
          if (deep_req_i) begin
            phase_d = PH_ENTER;
            code_d  = tgt_clamped;
          end else if (stop_clk_i) begin
            phase_d = PH_ENTER;
            code_d  = CODE_W'(2);
          end else if (halt_i) begin
            phase_d = PH_IDLE;
            code_d  = CODE_W'(1);
          end
        end
      end
      PH_ENTER: begin
        if (wake_ev_i) begin
          phase_d = PH_ACTIVE;
          code_d  = '0;
          wake_d  = 1'b1;
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_IDLE: begin
        if (wake_ev_i) begin
          if (lat_i == '0) begin
            phase_d = PH_ACTIVE;
            code_d  = '0;
            wake_d  = 1'b1;
          end else begin
            phase_d = PH_EXIT;
          end
        end
      end
      PH_EXIT: begin
        if (timer_last_i) begin
          phase_d = PH_ACTIVE;
          code_d  = '0;
          wake_d  = 1'b1;
        end
      end
      default: phase_d = PH_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ACTIVE;
      code_q  <= '0;
      wake_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      code_q  <= code_d;
      wake_q  <= wake_d;
    end
  end

  assign phase_o = phase_q;
  assign code_o  = code_q;
  assign wake_o  = wake_q;
endmodule

// File: rtl/cstate_ctrl.sv
module cstate_ctrl
  import cstate_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int THR_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     halt_i,
  input  logic                     stop_clk_i,
  input  logic                     deep_req_i,
  input  logic [2:0]               deep_tgt_i,
  input  logic                     irq_i,
  input  logic                     bm_write_i,
  input  logic                     bm_wake_en_i,
  input  logic [7:0]               ext_base_i,
  input  logic [6*LAT_W-1:0]       lat_cfg_i,
  input  logic                     thr_en_i,
  input  logic [THR_W-1:0]         thr_duty_i,
  output logic                     clk_en_o,
  output logic                     snoop_en_o,
  output logic [2:0]               cstate_o,
  output logic                     wake_o
);
  phase_e                  phase;
  code_t                   code;
  logic [1:0]              sem;
  logic                    wake_ev;
  logic                    load;
  logic                    timer_last;
  logic                    thr_gate;
  logic [LAT_W-1:0]        lat_sel;
  logic [NUM_CS-1:0][LAT_W-1:0] lat_tab;

  generate
    for (genvar k = 0; k < NUM_CS; k++) begin : g_lat
      if (k < 2) begin : g_zero
        assign lat_tab[k] = '0;
      end else begin : g_prog
        assign lat_tab[k] = lat_cfg_i[(k-2)*LAT_W +: LAT_W];
      end
    end
  endgenerate

  assign lat_sel = lat_tab[code];

  cstate_wake_eval u_wake (
    .code_i       (code),
    .ext_base_i   (ext_base_i),
    .irq_i        (irq_i),
    .bm_write_i   (bm_write_i),
    .bm_wake_en_i (bm_wake_en_i),
    .stop_clk_i   (stop_clk_i),
    .sem_o        (sem),
    .wake_o       (wake_ev)
  );

  cstate_fsm #(.LAT_W(LAT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_i       (halt_i),
    .stop_clk_i   (stop_clk_i),
    .deep_req_i   (deep_req_i),
    .deep_tgt_i   (deep_tgt_i),
    .irq_i        (irq_i),
    .wake_ev_i    (wake_ev),
    .lat_i        (lat_sel),
    .timer_last_i (timer_last),
    .phase_o      (phase),
    .code_o       (code),
    .wake_o       (wake_o),
    .load_o       (load)
  );

  cstate_exit_timer #(.LAT_W(LAT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (lat_sel),
    .last_o (timer_last)
  );

  cstate_throttle #(.THR_W(THR_W)) u_thr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (thr_en_i),
    .duty_i (thr_duty_i),
    .gate_o (thr_gate)
  );

  assign clk_en_o   = (phase == PH_ACTIVE) && thr_gate;
  assign snoop_en_o = !((phase == PH_IDLE) && (sem == 2'd3));
  assign cstate_o   = code;
endmodule

// File: rtl/cstate_ctrl_chk.sv
module cstate_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       irq_i,
  input logic       thr_en_i,
  input logic       clk_en_o,
  input logic       snoop_en_o,
  input logic [2:0] cstate_o,
  input logic       wake_o
);
  a_r12_clk_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o != 3'd0) |-> !clk_en_o);

  a_r9_wake_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  a_r9_wake_in_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (cstate_o == 3'd0));

  a_r7_snoop_off_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snoop_en_o |-> (cstate_o >= 3'd3));

  a_r2_c1_fast_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o == 3'd1 && irq_i) |=> (cstate_o == 3'd0 && wake_o));

  a_r2_c1_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o == 3'd1 && !irq_i) |=> (cstate_o == 3'd1));

  a_r11_no_throttle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o == 3'd0 && !thr_en_i) |-> clk_en_o);
endmodule

bind cstate_ctrl cstate_ctrl_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .thr_en_i   (thr_en_i),
  .clk_en_o   (clk_en_o),
  .snoop_en_o (snoop_en_o),
  .cstate_o   (cstate_o),
  .wake_o     (wake_o)
);

// File: tb/cstate_ctrl_tb_top.sv
`timescale 1ns/1ps
module cstate_ctrl_tb_top;
  localparam int LAT_W = 8;
  localparam int THR_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             halt_i = 1'b0, stop_clk_i = 1'b0, deep_req_i = 1'b0;
  logic [2:0]       deep_tgt_i = 3'd0;
  logic             irq_i = 1'b0, bm_write_i = 1'b0, bm_wake_en_i = 1'b0;
  logic [7:0]       ext_base_i;
  logic [6*LAT_W-1:0] lat_cfg_i;
  logic             thr_en_i = 1'b0;
  logic [THR_W-1:0] thr_duty_i = '0;
  logic             clk_en_o, snoop_en_o, wake_o;
  logic [2:0]       cstate_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  // bases for states 7,6,5,4 = 3,3,2,1 (R8)
  assign ext_base_i = {2'd3, 2'd3, 2'd2, 2'd1};
  // latencies for states 7..2 = 4,2,0,1,3,2 (R9)
  assign lat_cfg_i  = {8'd4, 8'd2, 8'd0, 8'd1, 8'd3, 8'd2};

  cstate_ctrl #(.LAT_W(LAT_W), .THR_W(THR_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(halt_i), .stop_clk_i(stop_clk_i),
    .deep_req_i(deep_req_i), .deep_tgt_i(deep_tgt_i), .irq_i(irq_i),
    .bm_write_i(bm_write_i), .bm_wake_en_i(bm_wake_en_i), .ext_base_i(ext_base_i),
    .lat_cfg_i(lat_cfg_i), .thr_en_i(thr_en_i), .thr_duty_i(thr_duty_i),
    .clk_en_o(clk_en_o), .snoop_en_o(snoop_en_o), .cstate_o(cstate_o), .wake_o(wake_o)
  );

  typedef struct packed {
    logic       h;
    logic       s;
    logic       d;
    logic [2:0] t;
    logic       i;
    logic       b;
    logic       e;
    logic [2:0] st;
    logic       c;
    logic       n;
    logic       w;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 44;
  // h s d t i b e | st c n w | req
  localparam vec_t TBL [NV] = '{
    '{1,0,0,0,0,0,0, 1,0,1,0, 2},   // R2 halt -> code 1 in one edge
    '{0,0,0,0,0,0,0, 1,0,1,0, 2},   // R2 stays
    '{0,0,0,0,0,1,1, 1,0,1,0, 7},   // R7 bm write ignored in base 1
    '{0,0,0,0,1,0,0, 0,1,1,1, 2},   // R2 irq -> C0 next edge
    '{0,0,0,0,0,0,0, 0,1,1,0, 9},   // R9 pulse single
    '{0,1,0,0,0,0,0, 2,0,1,0, 3},   // R3 entry phase
    '{0,1,0,0,0,0,0, 2,0,1,0, 3},   // R3 idle, snoop kept
    '{0,0,0,0,0,0,0, 2,0,1,0, 3},   // R3 release -> exit lat 2
    '{0,0,0,0,0,0,0, 2,0,1,0, 9},   // R9
    '{0,0,0,0,0,0,0, 0,1,1,1, 9},   // R9 wake after 2
    '{0,0,1,3,0,0,0, 3,0,1,0, 4},   // R4 deep entry
    '{0,0,0,0,0,0,0, 3,0,0,0, 7},   // R7 snoop off
    '{0,0,0,0,0,1,0, 3,0,0,0, 7},   // R7 bm write without enable ignored
    '{0,0,0,0,0,1,1, 3,0,1,0, 7},   // R7 bm write with enable wakes
    '{0,0,0,0,0,0,0, 3,0,1,0, 9},   // R9
    '{0,0,0,0,0,0,0, 3,0,1,0, 9},   // R9
    '{0,0,0,0,0,0,0, 0,1,1,1, 9},   // R9 wake after 3
    '{0,0,1,5,0,0,0, 5,0,1,0, 4},   // R4 extended entry
    '{0,0,0,0,0,0,0, 5,0,1,0, 8},   // R8 base 2 keeps snoop
    '{0,0,0,0,0,1,1, 5,0,1,0, 8},   // R8 base 2 ignores bm write
    '{0,0,0,0,1,0,0, 0,1,1,1, 6},   // R6 irq, lat 0
    '{0,0,1,6,0,0,0, 6,0,1,0, 4},   // R4
    '{0,0,0,0,0,0,0, 6,0,0,0, 8},   // R8 base 3 drops snoop
    '{0,0,0,0,0,1,1, 6,0,1,0, 8},   // R8 base 3 bm wake
    '{0,0,0,0,0,0,0, 6,0,1,0, 9},   // R9
    '{0,0,0,0,0,0,0, 0,1,1,1, 9},   // R9
    '{0,0,1,4,1,0,0, 0,1,1,0, 5},   // R5 irq suppresses entry
    '{0,0,1,7,0,0,0, 7,0,1,0, 4},   // R4
    '{0,0,0,0,1,0,0, 0,1,1,1,10},   // R10 abort during entry
    '{0,0,1,1,0,0,0, 3,0,1,0, 4},   // R4 target clamped to 3
    '{0,0,0,0,0,0,0, 3,0,0,0, 4},   // R4
    '{0,0,0,0,1,0,0, 3,0,1,0, 6},   // R6 irq wakes deep
    '{0,0,0,0,0,0,0, 3,0,1,0, 9},   // R9
    '{0,0,0,0,0,0,0, 3,0,1,0, 9},   // R9
    '{0,0,0,0,0,0,0, 0,1,1,1, 9},   // R9
    '{1,1,1,4,0,0,0, 4,0,1,0, 5},   // R5 software request wins
    '{0,0,0,0,0,0,0, 4,0,1,0, 8},   // R8 base 1 snoop on
    '{0,0,0,0,1,0,0, 4,0,1,0, 9},   // R9 lat 1 countdown
    '{0,0,0,0,0,0,0, 0,1,1,1, 9},   // R9
    '{1,1,0,0,0,0,0, 2,0,1,0, 5},   // R5 stop-clock wins over halt
    '{0,1,0,0,0,0,0, 2,0,1,0, 3},   // R3
    '{0,0,0,0,1,0,0, 2,0,1,0, 6},   // R6
    '{0,0,0,0,0,0,0, 2,0,1,0, 9},   // R9
    '{0,0,0,0,0,0,0, 0,1,1,1, 12}   // R12 clock back on
  };

  task automatic check_out(input string tag, input logic [2:0] st, input logic c,
                           input logic n, input logic w);
    checks++;
    if (cstate_o !== st || clk_en_o !== c || snoop_en_o !== n || wake_o !== w) begin
      errors++;
      $display("FAIL %s: got st=%0d clk=%b snp=%b wk=%b exp st=%0d clk=%b snp=%b wk=%b",
               tag, cstate_o, clk_en_o, snoop_en_o, wake_o, st, c, n, w);
    end
  endtask

  task automatic count_clk(input string tag, input int exp);
    int ones = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_i);
      if (clk_en_o) ones++;
    end
    checks++;
    if (ones != exp) begin
      errors++;
      $display("FAIL %s: clk_en high %0d of 16, expected %0d", tag, ones, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_out("R1 reset held", 3'd0, 1'b1, 1'b1, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R1 after reset", 3'd0, 1'b1, 1'b1, 1'b0);

    for (int v = 0; v < NV; v++) begin
      halt_i = TBL[v].h; stop_clk_i = TBL[v].s; deep_req_i = TBL[v].d;
      deep_tgt_i = TBL[v].t; irq_i = TBL[v].i; bm_write_i = TBL[v].b;
      bm_wake_en_i = TBL[v].e;
      @(negedge clk_i);
      check_out($sformatf("R%0d table step %0d", TBL[v].rq, v),
                TBL[v].st, TBL[v].c, TBL[v].n, TBL[v].w);
    end
    {halt_i, stop_clk_i, deep_req_i, irq_i, bm_write_i, bm_wake_en_i} = '0;
    deep_tgt_i = 3'd0;

    // R11 throttle
    thr_en_i = 1'b1; thr_duty_i = 4'd5;
    count_clk("R11 duty 5", 6);
    thr_duty_i = 4'd15;
    count_clk("R11 duty 15", 16);
    thr_duty_i = 4'd0;
    count_clk("R11 duty 0", 1);
    thr_en_i = 1'b0;
    count_clk("R11 disabled", 16);

    // R12 throttle has no effect in idle
    thr_en_i = 1'b1; thr_duty_i = 4'd15; halt_i = 1'b1;
    @(negedge clk_i);
    halt_i = 1'b0;
    count_clk("R12 idle with throttle", 0);
    check_out("R12 still code 1", 3'd1, 1'b0, 1'b1, 1'b0);
    irq_i = 1'b1;
    @(negedge clk_i);
    irq_i = 1'b0; thr_en_i = 1'b0;
    check_out("R2 wake from throttled idle", 3'd0, 1'b1, 1'b1, 1'b1);

    // R1 asynchronous reset from deep state
    deep_req_i = 1'b1; deep_tgt_i = 3'd7;
    @(negedge clk_i);
    deep_req_i = 1'b0;
    @(negedge clk_i);
    check_out("R4 code 7 idle", 3'd7, 1'b0, 1'b0, 1'b0);
    #1 rst_ni = 1'b0;
    #1 check_out("R1 async reset", 3'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R1 after second reset", 3'd0, 1'b1, 1'b1, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule